// File: doc/BRIEF.md
# RSSI Measurement and Clear-Channel Sequencer

This block runs one received-energy measurement each time it is started. It sits above a register access engine and talks to it over a simple request/acknowledge register bus. A measurement goes through these steps:

1. Read the radio's measurement control register.
2. Write that value back with the request bit set.
3. Poll the same register until its ready bit reads 1.
4. Read the averaged received-power byte from the long address space. The radio averages this value over 8 symbol periods.

The byte is latched and compared with a clear-channel threshold. A one-cycle `done` pulse reports the end of the measurement.

The latched value and the clear-channel decision stay on the outputs until the next successful measurement. Software can read the last result again without bus traffic. If the ready bit does not come up within a bounded number of polls, the sequence stops and raises an error flag with `done`. A start pulse that arrives while a measurement is running is ignored.

Top module: `rssi_cca_seq`

## Requirements
- R1: After an accepted start, the first bus transaction is a short-space read of address 0x3E (`bus_long`=0, `bus_wr`=0). The second is a short-space write to 0x3E whose data equals the value just read with bit 7 set and every other bit unchanged.
- R2: After that write, the block issues short-space reads of 0x3E, one at a time, until a read returns bit 0 = 1. The number of poll reads equals the index of the first ready read.
- R3: After the ready poll, the block issues exactly one long-space read (`bus_long`=1) of address 0x210. One cycle after its acknowledge, `rssi_val` holds the returned byte and `done` is high for exactly one cycle.
- R4: With a valid result, `chan_clear` is 1 exactly when `rssi_val` <= `CLEAR_MAX` (default 95): 95 gives 1 and 96 gives 0.
- R5: While idle, the block issues no bus request. `rssi_val` and `chan_clear` change only at the `done` of a successful measurement.
- R6: If `POLL_LIMIT` consecutive poll reads all return bit 0 = 0, the block pulses `done` with `timeout_err` = 1. It issues no long-space read, leaves `rssi_val`/`chan_clear` unchanged, and returns to idle. `timeout_err` stays set until the next accepted start.
- R7: A `start` pulse while `busy` is 1 is ignored. The running measurement makes the same transactions as without it, and no second measurement follows.
- R8: After reset, `busy`, `done`, `timeout_err`, `bus_req`, `chan_clear` are 0 and `rssi_val` is 0.
- R9: While `bus_req` is 1 and `bus_ack` is 0, the request fields (`bus_wr`, `bus_long`, `bus_addr`, `bus_wdata`) hold stable into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start one measurement (accepted only when idle) |
| bus_req | output | 1 | Register transaction request, held until acknowledged |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_long | output | 1 | 1 = long address space, 0 = short address space |
| bus_addr | output | 10 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | One-cycle completion of the current transaction |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| busy | output | 1 | A measurement is in progress |
| done | output | 1 | One-cycle end-of-measurement pulse |
| timeout_err | output | 1 | The last measurement ended because the ready bit never set |
| rssi_val | output | 8 | Last successfully measured averaged power byte |
| chan_clear | output | 1 | Last result at or below the clear-channel threshold |

## Verification
The poll timeout is the hardest case to reach from the ports. The bench's bus responder decides, for each run, after how many poll reads the ready bit appears. Runs set this to zero, to one less than the limit, to exactly the limit and to random values, so both the last allowed poll and the first failing one are covered. A start pulse is also injected while the sequencer waits on a poll. The bench then counts transactions by type to show that the pulse produced no extra traffic.

// File: rtl/rssi_cca_pkg.sv
package rssi_cca_pkg;

    localparam int BUS_ADDR_W = 10;
    localparam int BYTE_W     = 8;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_GET_CTRL = 3'd1,
        ST_SET_REQ  = 3'd2,
        ST_POLL     = 3'd3,
        ST_GET_RSSI = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic                  req;
        logic                  wr;
        logic                  long_sp;
        logic [BUS_ADDR_W-1:0] addr;
        logic [BYTE_W-1:0]     wdata;
    } bus_cmd_t;

    // Sets one bit of a byte and leaves the others as they were.
    function automatic logic [BYTE_W-1:0] with_bit_set(
        input logic [BYTE_W-1:0] v,
        input int unsigned       idx
    );
        logic [BYTE_W-1:0] r;
        r      = v;
        r[idx] = 1'b1;
        return r;
    endfunction

    // Clear-channel decision: at or below the limit counts as clear.
    function automatic logic at_or_below(
        input logic [BYTE_W-1:0] v,
        input logic [BYTE_W-1:0] lim
    );
        return v <= lim;
    endfunction

endpackage

// File: rtl/rssi_poll_timer.sv
module rssi_poll_timer #(
    parameter int POLL_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int CNT_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_last = (cnt_q == LAST);

endmodule

// File: rtl/rssi_seq_ctrl.sv
module rssi_seq_ctrl
    import rssi_cca_pkg::*;
#(
    parameter logic [BUS_ADDR_W-1:0] CTRL_ADDR = 10'h03E,
    parameter logic [BUS_ADDR_W-1:0] RSSI_ADDR = 10'h210,
    parameter int                    REQ_BIT   = 7,
    parameter int                    RDY_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              bus_ack,
    input  logic [BYTE_W-1:0] bus_rdata,
    input  logic              poll_at_last,
    output bus_cmd_t          cmd,
    output logic              busy,
    output logic              accept,
    output logic              tmr_clr,
    output logic              tmr_inc,
    output logic              capture,
    output logic              fail
);
    seq_state_e        state_q, state_d;
    logic [BYTE_W-1:0] ctrl_q;
    logic              rdy_seen;

    assign accept   = (state_q == ST_IDLE) && start;
    assign busy     = (state_q != ST_IDLE);
    assign rdy_seen = bus_rdata[RDY_BIT];

    always_comb begin
        state_d = state_q;
        tmr_inc = 1'b0;
        capture = 1'b0;
        fail    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_GET_CTRL;
            end
            ST_GET_CTRL: begin
                if (bus_ack) state_d = ST_SET_REQ;
            end
            ST_SET_REQ: begin
                if (bus_ack) state_d = ST_POLL;
            end
            ST_POLL: begin
                if (bus_ack) begin
                    if (rdy_seen) begin
                        state_d = ST_GET_RSSI;
                    end else if (poll_at_last) begin
                        state_d = ST_IDLE;
                        fail    = 1'b1;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end
            end
            ST_GET_RSSI: begin
                if (bus_ack) begin
                    state_d = ST_IDLE;
                    capture = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign tmr_clr = accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctrl_q  <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_GET_CTRL) && bus_ack) begin
                ctrl_q <= with_bit_set(bus_rdata, REQ_BIT);
            end
        end
    end

    always_comb begin
        cmd         = '0;
        cmd.addr    = CTRL_ADDR;
        unique case (state_q)
            ST_GET_CTRL: begin
                cmd.req = 1'b1;
            end
            ST_SET_REQ: begin
                cmd.req   = 1'b1;
                cmd.wr    = 1'b1;
                cmd.wdata = ctrl_q;
            end
            ST_POLL: begin
                cmd.req = 1'b1;
            end
            ST_GET_RSSI: begin
                cmd.req     = 1'b1;
                cmd.long_sp = 1'b1;
                cmd.addr    = RSSI_ADDR;
            end
            default: cmd.req = 1'b0;
        endcase
    end

endmodule

// File: rtl/rssi_result_hold.sv
module rssi_result_hold
    import rssi_cca_pkg::*;
#(
    parameter int CLEAR_MAX = 95
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic              fail,
    input  logic [BYTE_W-1:0] sample,
    output logic [BYTE_W-1:0] rssi_val,
    output logic              chan_clear,
    output logic              done,
    output logic              timeout_err
);
    localparam logic [BYTE_W-1:0] LIM = BYTE_W'(CLEAR_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            rssi_val    <= '0;
            chan_clear  <= 1'b0;
            done        <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            done <= capture || fail;
            if (capture) begin
                rssi_val   <= sample;
                chan_clear <= at_or_below(sample, LIM);
            end
            if (fail) begin
                timeout_err <= 1'b1;
            end else if (accept) begin
                timeout_err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rssi_cca_seq.sv
module rssi_cca_seq
    import rssi_cca_pkg::*;
#(
    parameter int                    POLL_LIMIT = 1024,
    parameter int                    CLEAR_MAX  = 95,
    parameter logic [BUS_ADDR_W-1:0] CTRL_ADDR  = 10'h03E,
    parameter logic [BUS_ADDR_W-1:0] RSSI_ADDR  = 10'h210,
    parameter int                    REQ_BIT    = 7,
    parameter int                    RDY_BIT    = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    output logic                  bus_req,
    output logic                  bus_wr,
    output logic                  bus_long,
    output logic [BUS_ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0]     bus_wdata,
    input  logic                  bus_ack,
    input  logic [BYTE_W-1:0]     bus_rdata,
    output logic                  busy,
    output logic                  done,
    output logic                  timeout_err,
    output logic [BYTE_W-1:0]     rssi_val,
    output logic                  chan_clear
);
    bus_cmd_t cmd;
    logic     accept, tmr_clr, tmr_inc, capture, fail, poll_at_last;

    rssi_seq_ctrl #(
        .CTRL_ADDR (CTRL_ADDR),
        .RSSI_ADDR (RSSI_ADDR),
        .REQ_BIT   (REQ_BIT),
        .RDY_BIT   (RDY_BIT)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .bus_ack      (bus_ack),
        .bus_rdata    (bus_rdata),
        .poll_at_last (poll_at_last),
        .cmd          (cmd),
        .busy         (busy),
        .accept       (accept),
        .tmr_clr      (tmr_clr),
        .tmr_inc      (tmr_inc),
        .capture      (capture),
        .fail         (fail)
    );

    rssi_poll_timer #(
        .POLL_LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .inc     (tmr_inc),
        .at_last (poll_at_last)
    );

    rssi_result_hold #(
        .CLEAR_MAX (CLEAR_MAX)
    ) u_result (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .capture     (capture),
        .fail        (fail),
        .sample      (bus_rdata),
        .rssi_val    (rssi_val),
        .chan_clear  (chan_clear),
        .done        (done),
        .timeout_err (timeout_err)
    );

    assign bus_req   = cmd.req;
    assign bus_wr    = cmd.wr;
    assign bus_long  = cmd.long_sp;
    assign bus_addr  = cmd.addr;
    assign bus_wdata = cmd.wdata;

endmodule

// File: rtl/rssi_cca_checker.sv
module rssi_cca_checker #(
    parameter int       CLEAR_MAX = 95,
    parameter int       REQ_BIT   = 7,
    parameter logic [9:0] CTRL_ADDR = 10'h03E,
    parameter logic [9:0] RSSI_ADDR = 10'h210
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_req,
    input logic       bus_wr,
    input logic       bus_long,
    input logic [9:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_ack,
    input logic       busy,
    input logic       done,
    input logic       timeout_err,
    input logic [7:0] rssi_val,
    input logic       chan_clear
);
    AST_WRITE_SETS_REQ: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_wr) |-> (bus_wdata[REQ_BIT] && !bus_long && bus_addr == CTRL_ADDR)); // R1

    AST_LONG_IS_RESULT: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_long) |-> (!bus_wr && bus_addr == RSSI_ADDR)); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3

    AST_CLEAR_MATCH: assert property (@(posedge clk) disable iff (rst)
        (done && !timeout_err) |-> (chan_clear == (rssi_val <= 8'(CLEAR_MAX)))); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req); // R5

    AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(rssi_val) |-> (done && !timeout_err)); // R5

    AST_ERR_RISES_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |-> done); // R6

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr)
                                   && $stable(bus_long) && $stable(bus_wdata))); // R9
endmodule

bind rssi_cca_seq rssi_cca_checker #(
    .CLEAR_MAX (CLEAR_MAX),
    .REQ_BIT   (REQ_BIT),
    .CTRL_ADDR (CTRL_ADDR),
    .RSSI_ADDR (RSSI_ADDR)
) u_rssi_cca_checker (
    .clk         (clk),
    .rst         (rst),
    .bus_req     (bus_req),
    .bus_wr      (bus_wr),
    .bus_long    (bus_long),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .rssi_val    (rssi_val),
    .chan_clear  (chan_clear)
);

// File: tb/test_rssi_cca_seq.sv
module test_rssi_cca_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 8;
    localparam int THRESH     = 95;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       bus_req, bus_wr, bus_long;
    logic [9:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_ack = 1'b0;
    logic [7:0] bus_rdata = 8'h00;
    logic       busy, done, timeout_err, chan_clear;
    logic [7:0] rssi_val;

    int total = 0;
    int bad   = 0;

    logic [7:0] exp_rssi  = 8'h00;
    logic       exp_clear = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rssi_cca_seq #(.POLL_LIMIT(LIMIT), .CLEAR_MAX(THRESH)) i_rssi_cca_seq (
        .clk(clk), .rst(rst), .start(start),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_long(bus_long),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .timeout_err(timeout_err),
        .rssi_val(rssi_val), .chan_clear(chan_clear)
    );

    function automatic logic model_clear(input logic [7:0] v);
        return v <= 8'(THRESH);
    endfunction

    function automatic int model_polls(input int rdy_after);
        return (rdy_after >= LIMIT) ? LIMIT : rdy_after + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One measurement. rdy_after = number of not-ready polls before the ready one.
    task automatic run_measure(input int rdy_after, input logic [7:0] rssi,
                               input logic [7:0] ctrl_init, input bit inject);
        int   n_txn = 0, n_poll = 0, n_wr = 0, n_long = 0, cyc = 0;
        bit   order_ok = 1'b1, wdata_ok = 1'b1, hung = 1'b0, injected = 1'b0;
        bit   timeout_exp;
        logic [7:0] ctrl;
        ctrl = ctrl_init & 8'hFE;
        timeout_exp = (rdy_after >= LIMIT);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            if (bus_ack) bus_ack = 1'b0;
            if (done) break;
            if (cyc > 2000) begin hung = 1'b1; break; end
            if (bus_req) begin
                int lat;
                lat = int'($urandom_range(0, 2));
                if (inject && !injected && n_txn == 2) begin
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    injected = 1'b1;
                    cyc++;
                end
                repeat (lat) begin @(negedge clk); cyc++; end
                if (n_txn == 0) begin
                    if (bus_wr || bus_long || bus_addr != 10'h03E) order_ok = 1'b0;
                    bus_rdata = ctrl;
                end else if (n_txn == 1) begin
                    if (!bus_wr || bus_long || bus_addr != 10'h03E) order_ok = 1'b0;
                    if (bus_wdata != (ctrl | 8'h80)) wdata_ok = 1'b0;
                    n_wr++;
                end else if (bus_long) begin
                    if (bus_wr || bus_addr != 10'h210) order_ok = 1'b0;
                    bus_rdata = rssi;
                    n_long++;
                end else begin
                    if (bus_wr) begin n_wr++; order_ok = 1'b0; end
                    if (bus_addr != 10'h03E) order_ok = 1'b0;
                    bus_rdata = (ctrl | 8'h80) & 8'hFE;
                    if (n_poll >= rdy_after) bus_rdata[0] = 1'b1;
                    n_poll++;
                end
                n_txn++;
                bus_ack = 1'b1;
            end
            @(negedge clk);
            cyc++;
        end
        bus_ack = 1'b0;
        check(!hung, "R3 done reached", int'(hung), 0);
        check(order_ok, "R1 transaction order/address", int'(order_ok), 1);
        check(wdata_ok && n_wr == 1, "R1 write data keeps bits, sets bit7", n_wr, 1);
        check(n_poll == model_polls(rdy_after), "R2 poll count", n_poll, model_polls(rdy_after));
        check(timeout_err == timeout_exp, "R6 timeout_err", int'(timeout_err), int'(timeout_exp));
        check(n_long == (timeout_exp ? 0 : 1), "R6 long read count", n_long, timeout_exp ? 0 : 1);
        if (!timeout_exp) begin
            exp_rssi  = rssi;
            exp_clear = model_clear(rssi);
        end
        check(rssi_val == exp_rssi, "R3 rssi_val", int'(rssi_val), int'(exp_rssi));
        check(chan_clear == exp_clear, "R4 chan_clear", int'(chan_clear), int'(exp_clear));
        if (inject)
            check(injected && n_txn == 3 + model_polls(rdy_after) - (timeout_exp ? 1 : 0),
                  "R7 start while busy ignored", n_txn,
                  3 + model_polls(rdy_after) - (timeout_exp ? 1 : 0));
        @(negedge clk);
        check(!done, "R3 done one cycle", int'(done), 0);
        check(!busy, "R6 back to idle", int'(busy), 0);
    endtask

    task automatic check_quiet(input int cycles);
        bit any_req = 1'b0, moved = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (bus_req) any_req = 1'b1;
            if (rssi_val != exp_rssi || chan_clear != exp_clear) moved = 1'b1;
        end
        check(!any_req, "R5 no bus request while idle", int'(any_req), 0);
        check(!moved, "R5 result held", int'(rssi_val), int'(exp_rssi));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !timeout_err && !bus_req && !chan_clear && rssi_val == 8'h00,
              "R8 reset state", int'(rssi_val), 0);

        run_measure(0, 8'd95, 8'h00, 1'b0);          // R4 boundary: clear
        run_measure(2, 8'd96, 8'h3C, 1'b0);          // R4 boundary: busy
        check_quiet(20);                             // R5
        run_measure(LIMIT - 1, 8'd0, 8'h7E, 1'b0);   // R2 last allowed poll
        run_measure(LIMIT, 8'd200, 8'h55, 1'b0);     // R6 timeout, result kept
        check_quiet(10);
        run_measure(1, 8'd255, 8'hFF, 1'b0);         // R6 err cleared by new start
        run_measure(3, 8'd40, 8'hA2, 1'b1);          // R7 injected start
        run_measure(LIMIT + 2, 8'd10, 8'h01, 1'b1);  // R7 during timeout run

        for (int k = 0; k < 25; k++) begin
            int ra;
            ra = int'($urandom_range(0, LIMIT + 1));
            run_measure(ra, 8'($urandom), 8'($urandom), 1'($urandom));
            if (k % 8 == 0) check_quiet(5);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule